// File: doc/BRIEF.md
# Warm Reset Sequencing Controller

This block gathers a set of internal warm reset requests and a software request, and turns any enabled one into a low pulse on a shared, open-drain style reset pad. The pulse width is programmable. The same pad can also be pulled low from outside the chip. The block filters that external activity through two programmable delays, one before the internal warm reset is asserted and one before it is released. The internal warm reset output is registered and synchronous to the reference clock. It stays high for as long as a warm reset sequence is in progress.

Each delay field is a 4-bit exponent. Code n selects TICKS·2^n reference cycles, where TICKS is the number of cycles in the 500 ns base unit. The block keeps a sticky record of what caused each warm reset. Software can clear that record. The record is not affected by the warm reset, and only cold reset or an explicit clear wipes it. Software uses a small register port with a write strobe and a combinational read path.

Register map, 12-bit data:
- Address 0 holds the source enables, one bit per source, in bits [NUM_SRC-1:0].
- Address 1 holds the timing codes: pad pulse width in [3:0], external release delay in [7:4] and external assert delay in [11:8].
- Address 2 is a command register. Writing bit 0 as 1 requests a warm reset, and writing bit 1 as 1 clears the cause record. It reads as 0.
- Address 3 is the read-only cause record. Bits [NUM_SRC-1:0] are the internal sources, bit NUM_SRC is software and bit NUM_SRC+1 is the external pad.

Top module: `warm_rst_ctrl`

## Requirements
- R1: After cold reset `pad_oe_o` and `warm_rst_o` are 0, and the enable, timing and cause registers all read 0.
- R2: A request on a source whose enable bit (address 0) is 0 neither drives the pad nor sets any cause bit.
- R3: When an enabled source request is sampled while the block is idle, `pad_oe_o` rises on the next cycle and stays high for exactly TICKS·2^P cycles, where P is timing bits [3:0]. `warm_rst_o` is high whenever `pad_oe_o` is high.
- R4: Writing 1 to bit 0 of address 2 starts the same pad pulse as a source request and sets cause bit NUM_SRC.
- R5: Each timing code n gives a window of TICKS·2^n reference cycles. Larger codes double the window for each step.
- R6: After the pad input goes low while idle, `warm_rst_o` rises A+3 cycles later, where A = TICKS·2^(bits [11:8]). The 3 cycles are two synchroniser stages and one state register. Cause bit NUM_SRC+1 is then set.
- R7: After the externally held pad is released, `warm_rst_o` falls D+3 cycles later, where D = TICKS·2^(bits [7:4]).
- R8: If the pad returns high before the assert window ends, no warm reset occurs. If the pad goes low again during the release window, the release window starts over when the pad is released again.
- R9: Cause bits accumulate. Every source that triggers is recorded, and bits stay set across later warm resets.
- R10: Writing 1 to bit 1 of address 2 clears the cause record to 0.
- R11: The block's own pad pulse is never taken as an external event. `warm_rst_o` falls 3 cycles after `pad_oe_o` falls, and the external cause bit stays 0.
- R12: Source or software requests that arrive while a warm reset is in progress are ignored and are not recorded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Active-low cold reset, asynchronous |
| src_req_i | input | NUM_SRC | Internal warm reset requests, one per source |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register write address |
| wr_data_i | input | 12 | Register write data |
| rd_addr_i | input | 2 | Register read address |
| rd_data_o | output | 12 | Register read data, combinational |
| pad_i | input | 1 | Reset pad level as seen at the pad input |
| pad_oe_o | output | 1 | Drives the pad low when 1 |
| warm_rst_o | output | 1 | Synchronous warm reset to the chip, active high |

## Verification
The assertions check on every cycle that the pad is never driven without a warm reset in progress and that every pad pulse follows an enabled or software request. They also check that cause bits only fall on a clear, that no request is recorded mid-sequence, that the block's own pulse never leads into the external assert path, and that the timer counts down one step per cycle. Only the bench scenarios can show the exact pulse widths and delay windows for different codes, the effect of bounce on each window, and the register values read back after masked requests.

// File: rtl/warm_rst_pkg.sv
package warm_rst_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_DRIVE    = 3'd1,
        ST_RELEASE  = 3'd2,
        ST_EXT_WAIT = 3'd3,
        ST_EXT_ON   = 3'd4,
        ST_EXT_OFF  = 3'd5
    } wrst_state_e;

    localparam logic [1:0] ADDR_ENABLE = 2'd0;
    localparam logic [1:0] ADDR_TIMING = 2'd1;
    localparam logic [1:0] ADDR_CMD    = 2'd2;
    localparam logic [1:0] ADDR_CAUSE  = 2'd3;

    localparam int CMD_SW_BIT  = 0;
    localparam int CMD_CLR_BIT = 1;

    localparam int CODE_W      = 4;
    localparam int PULSE_LSB   = 0;
    localparam int RELEASE_LSB = 4;
    localparam int ASSERT_LSB  = 8;

endpackage

// File: rtl/wrst_sync.sv
module wrst_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], d_i};
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '1;
        else         chain_q <= chain_d;
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/wrst_timer.sv
module wrst_timer #(
    parameter int TICKS  = 125,
    parameter int CODE_W = 4
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              start_i,
    input  logic [CODE_W-1:0] code_i,
    output logic              done_o
);
    localparam int CNT_W = $clog2(TICKS + 1) + (2 ** CODE_W);

    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (start_i) begin
            tmr_d.busy = 1'b1;
            tmr_d.cnt  = (CNT_W'(TICKS) << code_i) - CNT_W'(1);
        end else if (tmr_q.busy) begin
            if (tmr_q.cnt == '0) tmr_d.busy = 1'b0;
            else                 tmr_d.cnt  = tmr_q.cnt - CNT_W'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) tmr_q <= '0;
        else         tmr_q <= tmr_d;
    end

    assign done_o = tmr_q.busy && (tmr_q.cnt == '0);

    a_r5_count_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tmr_q.busy && tmr_q.cnt != '0 && !start_i) |=> (tmr_q.cnt == $past(tmr_q.cnt) - CNT_W'(1)));
endmodule

// File: rtl/warm_rst_ctrl.sv
module warm_rst_ctrl
    import warm_rst_pkg::*;
#(
    parameter int NUM_SRC = 4,
    parameter int TICKS   = 125,
    parameter int DATA_W  = 12
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [NUM_SRC-1:0] src_req_i,
    input  logic               wr_en_i,
    input  logic [1:0]         wr_addr_i,
    input  logic [DATA_W-1:0]  wr_data_i,
    input  logic [1:0]         rd_addr_i,
    output logic [DATA_W-1:0]  rd_data_o,
    input  logic               pad_i,
    output logic               pad_oe_o,
    output logic               warm_rst_o
);
    localparam int CAUSE_W = NUM_SRC + 2;
    localparam int SW_BIT  = NUM_SRC;
    localparam int EXT_BIT = NUM_SRC + 1;
    localparam int TIM_W   = 3 * CODE_W;

    typedef struct packed {
        wrst_state_e        state;
        logic [NUM_SRC-1:0] en;
        logic [TIM_W-1:0]   tim;
        logic [CAUSE_W-1:0] cause;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic              pad_s;
    logic              tmr_start;
    logic [CODE_W-1:0] tmr_code;
    logic              tmr_done;
    logic              sw_req, clr_req;
    logic [NUM_SRC-1:0] trig_vec;
    logic [CAUSE_W-1:0] cause_set;

    wrst_sync #(.STAGES(2)) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .d_i    (pad_i),
        .q_o    (pad_s)
    );

    wrst_timer #(.TICKS(TICKS), .CODE_W(CODE_W)) u_timer (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .start_i (tmr_start),
        .code_i  (tmr_code),
        .done_o  (tmr_done)
    );

    assign sw_req   = wr_en_i && (wr_addr_i == ADDR_CMD) && wr_data_i[CMD_SW_BIT];
    assign clr_req  = wr_en_i && (wr_addr_i == ADDR_CMD) && wr_data_i[CMD_CLR_BIT];
    assign trig_vec = src_req_i & ctl_q.en;

    always_comb begin
        ctl_d     = ctl_q;
        tmr_start = 1'b0;
        tmr_code  = '0;
        cause_set = '0;

        if (wr_en_i && wr_addr_i == ADDR_ENABLE) ctl_d.en  = wr_data_i[NUM_SRC-1:0];
        if (wr_en_i && wr_addr_i == ADDR_TIMING) ctl_d.tim = wr_data_i[TIM_W-1:0];

        unique case (ctl_q.state)
            ST_IDLE: begin
                if ((|trig_vec) || sw_req) begin
                    ctl_d.state          = ST_DRIVE;
                    tmr_start            = 1'b1;
                    tmr_code             = ctl_q.tim[PULSE_LSB +: CODE_W];
                    cause_set[NUM_SRC-1:0] = trig_vec;
                    cause_set[SW_BIT]    = sw_req;
                end else if (!pad_s) begin
                    ctl_d.state = ST_EXT_WAIT;
                    tmr_start   = 1'b1;
                    tmr_code    = ctl_q.tim[ASSERT_LSB +: CODE_W];
                end
            end
            ST_DRIVE: begin
                if (tmr_done) ctl_d.state = ST_RELEASE;
            end
            ST_RELEASE: begin
                if (pad_s) ctl_d.state = ST_IDLE;
            end
            ST_EXT_WAIT: begin
                if (pad_s) begin
                    ctl_d.state = ST_IDLE;
                end else if (tmr_done) begin
                    ctl_d.state        = ST_EXT_ON;
                    cause_set[EXT_BIT] = 1'b1;
                end
            end
            ST_EXT_ON: begin
                if (pad_s) begin
                    ctl_d.state = ST_EXT_OFF;
                    tmr_start   = 1'b1;
                    tmr_code    = ctl_q.tim[RELEASE_LSB +: CODE_W];
                end
            end
            ST_EXT_OFF: begin
                if (!pad_s)        ctl_d.state = ST_EXT_ON;
                else if (tmr_done) ctl_d.state = ST_IDLE;
            end
            default: ctl_d.state = ST_IDLE;
        endcase

        ctl_d.cause = (clr_req ? '0 : ctl_q.cause) | cause_set;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ctl_q.state <= ST_IDLE;
            ctl_q.en    <= '0;
            ctl_q.tim   <= '0;
            ctl_q.cause <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign pad_oe_o   = (ctl_q.state == ST_DRIVE);
    assign warm_rst_o = (ctl_q.state == ST_DRIVE) || (ctl_q.state == ST_RELEASE) ||
                        (ctl_q.state == ST_EXT_ON) || (ctl_q.state == ST_EXT_OFF);

    always_comb begin
        rd_data_o = '0;
        unique case (rd_addr_i)
            ADDR_ENABLE: rd_data_o[NUM_SRC-1:0] = ctl_q.en;
            ADDR_TIMING: rd_data_o[TIM_W-1:0]   = ctl_q.tim;
            ADDR_CAUSE:  rd_data_o[CAUSE_W-1:0] = ctl_q.cause;
            default:     rd_data_o = '0;
        endcase
    end

    a_r3_oe_implies_warm: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pad_oe_o |-> warm_rst_o);

    a_r2_pulse_needs_request: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(pad_oe_o) |-> $past((|(src_req_i & ctl_q.en)) || sw_req));

    a_r9_cause_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !clr_req |=> ((ctl_q.cause & $past(ctl_q.cause)) == $past(ctl_q.cause)));

    a_r12_no_record_midway: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ctl_q.state != ST_IDLE && !clr_req) |=> (ctl_q.cause[SW_BIT:0] == $past(ctl_q.cause[SW_BIT:0])));

    a_r11_no_self_trigger: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ctl_q.state == ST_RELEASE) |=> (ctl_q.state == ST_RELEASE || ctl_q.state == ST_IDLE));
endmodule

// File: tb/warm_rst_ctrl_test.sv
module warm_rst_ctrl_test;
    localparam int NS = 4;
    localparam int TK = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NS-1:0] src_req = '0;
    logic          wr_en = 1'b0;
    logic [1:0]    wr_addr = '0;
    logic [11:0]   wr_data = '0;
    logic [1:0]    rd_addr = '0;
    logic [11:0]   rd_data;
    logic          pad_i;
    logic          pad_oe;
    logic          warm;
    logic          ext_low = 1'b0;

    int n_tests = 0;
    int n_fail  = 0;
    int exp_q[$];
    int oe_w = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    assign pad_i = (pad_oe || ext_low) ? 1'b0 : 1'b1;

    warm_rst_ctrl #(.NUM_SRC(NS), .TICKS(TK), .DATA_W(12)) uut (
        .clk_i(clk), .rst_ni(rst_n), .src_req_i(src_req),
        .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
        .rd_addr_i(rd_addr), .rd_data_o(rd_data),
        .pad_i(pad_i), .pad_oe_o(pad_oe), .warm_rst_o(warm)
    );

    task automatic chk(string req, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Scoreboard monitor: measures each pad pulse and compares against queued widths
    always @(negedge clk) begin
        if (rst_n) begin
            if (pad_oe) oe_w++;
            else if (oe_w > 0) begin
                if (exp_q.size() == 0) chk("R2 unexpected pad pulse", oe_w, 0);
                else chk("R3/R5 pad pulse width", oe_w, exp_q.pop_front());
                oe_w = 0;
            end
        end
    end

    task automatic wr(input logic [1:0] a, input logic [11:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output int v);
        @(negedge clk);
        rd_addr = a;
        #1 v = int'(rd_data);
    endtask

    task automatic pulse_src(input int idx);
        @(negedge clk);
        src_req[idx] = 1'b1;
        @(negedge clk);
        src_req[idx] = 1'b0;
    endtask

    task automatic wait_idle();
        while (warm) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    initial begin
        #(4 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual 0 expected 1");
        if (!finished) begin
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int v;
        int k;
        bit seen;
        repeat (3) @(negedge clk);
        chk("R1 pad_oe at reset", int'(pad_oe), 0);
        chk("R1 warm at reset", int'(warm), 0);
        rst_n = 1'b1;
        rd(2'd3, v); chk("R1 cause at reset", v, 0);
        rd(2'd0, v); chk("R1 enable at reset", v, 0);
        rd(2'd1, v); chk("R1 timing at reset", v, 0);

        // pulse code 1 (4 cycles), release code 2 (8), assert code 3 (16)
        wr(2'd1, {4'd3, 4'd2, 4'd1});
        wr(2'd0, 12'b0101);

        // R2: disabled source ignored
        pulse_src(1);
        repeat (10) @(negedge clk);
        chk("R2 warm after masked request", int'(warm), 0);
        rd(2'd3, v); chk("R2 cause after masked request", v, 0);

        // R3 / R11 / R12: enabled source, own readback ignored, mid-sequence request ignored
        exp_q.push_back(4);
        @(negedge clk);
        src_req[0] = 1'b1;
        @(negedge clk);
        src_req[0] = 1'b0;
        chk("R3 pad driven the cycle after request", int'(pad_oe), 1);
        src_req[2] = 1'b1;
        @(negedge clk);
        src_req[2] = 1'b0;
        while (pad_oe) @(negedge clk);
        k = 0;
        while (warm) begin k++; @(negedge clk); end
        chk("R11 warm falls 3 cycles after pad release", k, 3);
        repeat (2) @(negedge clk);
        rd(2'd3, v); chk("R9/R11/R12 cause after source 0", v, 12'h001);

        // R4: software request, code 2 -> 8 cycles
        wr(2'd1, {4'd3, 4'd2, 4'd2});
        exp_q.push_back(8);
        wr(2'd2, 12'b01);
        wait_idle();
        rd(2'd3, v); chk("R4/R9 cause accumulates software bit", v, 12'h011);

        // R10: clear
        wr(2'd2, 12'b10);
        rd(2'd3, v); chk("R10 cause cleared", v, 0);

        // R5: code 4 -> 32 cycles
        wr(2'd1, {4'd3, 4'd2, 4'd4});
        exp_q.push_back(32);
        pulse_src(2);
        wait_idle();
        rd(2'd3, v); chk("R5 cause after source 2", v, 12'h004);
        wr(2'd2, 12'b10);

        // R6: external assert after 16+3 cycles
        @(negedge clk);
        ext_low = 1'b1;
        k = 0;
        while (!warm && k < 100) begin @(negedge clk); k++; end
        chk("R6 external assert delay", k, 19);
        rd(2'd3, v); chk("R6 external cause bit", v, 12'h020);

        // R7: external release after 8+3 cycles
        @(negedge clk);
        ext_low = 1'b0;
        k = 0;
        while (warm && k < 100) begin @(negedge clk); k++; end
        chk("R7 external release delay", k, 11);
        wr(2'd2, 12'b10);

        // R8: short bounce during assert window
        @(negedge clk);
        ext_low = 1'b1;
        repeat (5) @(negedge clk);
        ext_low = 1'b0;
        seen = 1'b0;
        repeat (30) begin @(negedge clk); if (warm) seen = 1'b1; end
        chk("R8 bounce in assert window gives no reset", int'(seen), 0);
        rd(2'd3, v); chk("R8 no cause after bounce", v, 0);

        // R8: bounce during release window restarts it
        @(negedge clk);
        ext_low = 1'b1;
        repeat (25) @(negedge clk);
        chk("R8 external reset asserted", int'(warm), 1);
        ext_low = 1'b0;
        repeat (4) @(negedge clk);
        ext_low = 1'b1;
        repeat (2) @(negedge clk);
        chk("R8 warm held during release bounce", int'(warm), 1);
        ext_low = 1'b0;
        k = 0;
        while (warm && k < 100) begin @(negedge clk); k++; end
        chk("R8 release window restarted", k, 11);

        repeat (5) @(negedge clk);
        chk("R3 all expected pulses observed", exp_q.size(), 0);
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule